// File: doc/BRIEF.md
# Stereo Bitstream DAC Register Front End

This block is the bus-facing side of a stereo one-bit audio converter. Software, or a DMA engine, writes packed stereo frames into a holding register over a simple 32-bit register bus. A separate sample clock runs at 256 times the audio frame rate. Once per 256 of its cycles the block moves the waiting frame into an output stage, and the output stage feeds the left and right 16-bit samples to a downstream modulator. The frame tick crosses into the bus domain as a toggle followed by a synchronizer chain.

Two events drive an interrupt line through a maskable status register. The first is transmit-ready: the holding register has been consumed and can take the next frame. The second is underrun: a tick arrived while no fresh frame was waiting, so the previous frame was played again. Mask bits are changed only through separate write-one-to-set and write-one-to-clear addresses. Status bits are dropped through a write-one-to-clear address.

A control register carries a converter enable and a channel swap. While the block is disabled, frame ticks are ignored and a data write goes straight to the output stage. Writing zero there silences the converter, and the output stays at that value.

Top module: `audio_bsdac_regs`

## Requirements
- R1: After reset, every readable register returns zero, the interrupt output is low and both sample outputs are zero.
- R2: The bus decodes byte offsets 0x00 (frame data), 0x08 (control), 0x0C (mask, read), 0x10 (mask set), 0x14 (mask clear), 0x18 (status clear) and 0x1C (status, read). Frame data reads back the last value written. Control keeps only bit 31 (enable) and bit 30 (swap), and all other bits read as zero.
- R3: In the mask, status, set and clear registers, bit 28 is underrun and bit 29 is transmit-ready. A one written to mask-set sets the matching mask bit, and a one written to mask-clear clears it. Zeros leave mask bits unchanged, and every other mask bit reads as zero.
- R4: A one written to status-clear drops the matching status bit. Every other bit written there has no effect.
- R5: While enabled, a frame tick occurs every 256 sample-clock cycles. A tick that finds a frame waiting moves it to the output stage and sets transmit-ready. The outputs change exactly 256 bus cycles apart when the bus clock and the sample clock are equal.
- R6: While enabled, a tick that finds no fresh frame sets underrun and leaves the output stage unchanged.
- R7: A frame data write clears transmit-ready. When the write falls in the same cycle as a tick, the tick consumes the previous holding state, the written frame becomes the waiting frame, and transmit-ready ends up clear.
- R8: While disabled, ticks change neither status nor outputs, and a data write loads the output stage at once. Writing zero gives silent outputs, and they stay silent.
- R9: The left sample is data bits 31:16 and the right sample is bits 15:0. With swap set, the two outputs are exchanged.
- R10: The interrupt output is high exactly when some status bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| sampleClk | input | 1 | Sample clock, 256 times the frame rate |
| busAddr | input | 5 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one bus cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| irqOut | output | 1 | Level interrupt |
| leftOut | output | 16 | Left sample to the modulator |
| rightOut | output | 16 | Right sample to the modulator |

## Verification
The collision of interest is a frame data write that lands in the same bus cycle as a synchronized frame tick. It is tested once with the holding register empty and once with it full. The bench runs both clocks from one source. It finds the first tick by polling the underrun status, and from that point it schedules writes for exact later tick edges. In each case it judges the result from the outputs, the status bits, the readback of the waiting frame, and the transfer one tick later.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;

  localparam int BUS_W     = 32;
  localparam int BIT_EN    = 31;
  localparam int BIT_SWAP  = 30;
  localparam int BIT_TXRDY = 29;
  localparam int BIT_UNDR  = 28;

  // word index = byte offset / 4
  localparam logic [2:0] IDX_DATA = 3'd0;
  localparam logic [2:0] IDX_CTRL = 3'd2;
  localparam logic [2:0] IDX_MASK = 3'd3;
  localparam logic [2:0] IDX_MSET = 3'd4;
  localparam logic [2:0] IDX_MCLR = 3'd5;
  localparam logic [2:0] IDX_SCLR = 3'd6;
  localparam logic [2:0] IDX_STAT = 3'd7;

  typedef struct packed {
    logic wrData;
    logic wrCtrl;
    logic wrMaskSet;
    logic wrMaskClr;
    logic wrStatClr;
    logic frameTick;
  } dacStrobes_t;

endpackage

// File: rtl/frame_tick_gen.sv
module frame_tick_gen #(
  parameter int FRAME_LEN = 256
) (
  input  logic sampleClk,
  input  logic rstN,
  output logic tickToggle
);
  localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] phaseCnt;

  always_ff @(posedge sampleClk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt   <= '0;
      tickToggle <= 1'b0;
    end else if (phaseCnt == LAST) begin
      phaseCnt   <= '0;
      tickToggle <= ~tickToggle;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end
endmodule

// File: rtl/dac_ctrl.sv
module dac_ctrl
  import dac_regs_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              tickToggle,
  output dacStrobes_t       strb,
  output logic [2:0]        rdIdx
);
  localparam int IDX_W = ADDR_W - 2;

  logic [SYNC_STAGES:0] syncQ;
  logic                 aligned;
  logic [IDX_W-1:0]     wordIdx;
  logic                 wrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], tickToggle};
  end

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[ADDR_W-1:2];
  assign rdIdx   = aligned ? 3'(wordIdx) : IDX_MASK ^ 3'd2; // index 1: reads zero
  assign wrHit   = busWrEn && aligned;

  always_comb begin
    strb           = '0;
    strb.frameTick = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];
    strb.wrData    = wrHit && (wordIdx == IDX_W'(IDX_DATA));
    strb.wrCtrl    = wrHit && (wordIdx == IDX_W'(IDX_CTRL));
    strb.wrMaskSet = wrHit && (wordIdx == IDX_W'(IDX_MSET));
    strb.wrMaskClr = wrHit && (wordIdx == IDX_W'(IDX_MCLR));
    strb.wrStatClr = wrHit && (wordIdx == IDX_W'(IDX_SCLR));
  end
endmodule

// File: rtl/dac_datapath.sv
module dac_datapath
  import dac_regs_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dacStrobes_t         strb,
  input  logic [2:0]          rdIdx,
  input  logic [BUS_W-1:0]    busWrData,
  output logic [BUS_W-1:0]    busRdData,
  output logic                irqOut,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic [1:0]          statQ,
  output logic [1:0]          maskQ,
  output logic                enQ,
  output logic                holdFull
);
  localparam int FRAME_W = 2 * SAMPLE_W;

  logic [FRAME_W-1:0] holdQ;
  logic [FRAME_W-1:0] outQ;
  logic               swapQ;
  logic               consume;
  logic [1:0]         evtBits;

  assign consume = strb.frameTick && enQ;
  assign evtBits = busWrData[BIT_TXRDY:BIT_UNDR];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      swapQ <= 1'b0;
    end else if (strb.wrCtrl) begin
      enQ   <= busWrData[BIT_EN];
      swapQ <= busWrData[BIT_SWAP];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ    <= '0;
      outQ     <= '0;
      holdFull <= 1'b0;
    end else begin
      if (consume && holdFull) begin
        outQ     <= holdQ;
        holdFull <= 1'b0;
      end
      if (strb.wrData) begin
        holdQ <= busWrData[FRAME_W-1:0];
        if (enQ) begin
          holdFull <= 1'b1;
        end else begin
          outQ     <= busWrData[FRAME_W-1:0];
          holdFull <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
    end else begin
      if (strb.wrData)                       statQ[1] <= 1'b0;
      else if (consume && holdFull)          statQ[1] <= 1'b1;
      else if (strb.wrStatClr && evtBits[1]) statQ[1] <= 1'b0;

      if (consume && !holdFull)              statQ[0] <= 1'b1;
      else if (strb.wrStatClr && evtBits[0]) statQ[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               maskQ <= '0;
    else if (strb.wrMaskSet) maskQ <= maskQ | evtBits;
    else if (strb.wrMaskClr) maskQ <= maskQ & ~evtBits;
  end

  assign irqOut   = |(statQ & maskQ);
  assign leftOut  = swapQ ? outQ[SAMPLE_W-1:0] : outQ[FRAME_W-1:SAMPLE_W];
  assign rightOut = swapQ ? outQ[FRAME_W-1:SAMPLE_W] : outQ[SAMPLE_W-1:0];

  always_comb begin
    busRdData = '0;
    case (rdIdx)
      IDX_DATA: busRdData[FRAME_W-1:0] = holdQ;
      IDX_CTRL: begin
        busRdData[BIT_EN]   = enQ;
        busRdData[BIT_SWAP] = swapQ;
      end
      IDX_MASK: busRdData[BIT_TXRDY:BIT_UNDR] = maskQ;
      IDX_STAT: busRdData[BIT_TXRDY:BIT_UNDR] = statQ;
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/audio_bsdac_regs.sv
module audio_bsdac_regs
  import dac_regs_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SAMPLE_W    = 16,
  parameter int FRAME_LEN   = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleClk,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  output logic                irqOut,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut
);
  logic        tickToggle;
  dacStrobes_t strb;
  logic [2:0]  rdIdx;
  logic [1:0]  statQ;
  logic [1:0]  maskQ;
  logic        enQ;
  logic        holdFull;

  frame_tick_gen #(.FRAME_LEN(FRAME_LEN)) u_tick (
    .sampleClk (sampleClk),
    .rstN      (rstN),
    .tickToggle(tickToggle)
  );

  dac_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .tickToggle(tickToggle),
    .strb      (strb),
    .rdIdx     (rdIdx)
  );

  dac_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdIdx    (rdIdx),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .irqOut   (irqOut),
    .leftOut  (leftOut),
    .rightOut (rightOut),
    .statQ    (statQ),
    .maskQ    (maskQ),
    .enQ      (enQ),
    .holdFull (holdFull)
  );
endmodule

// File: rtl/audio_bsdac_regs_chk.sv
module audio_bsdac_regs_chk
  import dac_regs_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input dacStrobes_t         strb,
  input logic [31:0]         busWrData,
  input logic [1:0]          statQ,
  input logic [1:0]          maskQ,
  input logic                enQ,
  input logic                holdFull,
  input logic [SAMPLE_W-1:0] leftOut,
  input logic [SAMPLE_W-1:0] rightOut
);
  a_r2_single_decode: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrData, strb.wrCtrl, strb.wrMaskSet, strb.wrMaskClr, strb.wrStatClr}));

  a_r3_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMaskSet |=> ((maskQ & $past(busWrData[29:28])) == $past(busWrData[29:28])));

  a_r3_mask_clr: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMaskClr |=> ((maskQ & $past(busWrData[29:28])) == 2'b00));

  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStatClr && !strb.frameTick) |=> ((statQ & $past(busWrData[29:28])) == 2'b00));

  a_r5_ready_on_move: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameTick && enQ && holdFull && !strb.wrData) |=> (statQ[1] && !holdFull));

  a_r6_underrun_repeat: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameTick && enQ && !holdFull && !strb.wrCtrl)
      |=> (statQ[0] && $stable(leftOut) && $stable(rightOut)));

  a_r7_write_clears_ready: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> !statQ[1]);

  a_r8_idle_tick: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameTick && !enQ && !strb.wrData && !strb.wrCtrl && !strb.wrStatClr)
      |=> ($stable(statQ) && $stable(leftOut) && $stable(rightOut)));
endmodule

bind audio_bsdac_regs audio_bsdac_regs_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .busWrData(busWrData),
  .statQ    (statQ),
  .maskQ    (maskQ),
  .enQ      (enQ),
  .holdFull (holdFull),
  .leftOut  (leftOut),
  .rightOut (rightOut)
);

// File: tb/audio_bsdac_regs_bench.sv
module audio_bsdac_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_DATA = 5'h00, A_CTRL = 5'h08, A_MASK = 5'h0C,
                         A_MSET = 5'h10, A_MCLR = 5'h14, A_SCLR = 5'h18, A_STAT = 5'h1C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;
  logic [15:0] leftOut, rightOut;

  int cyc = 0;
  int errors = 0;
  int checks = 0;

  logic [31:0] outM;
  logic        swapM;
  logic [1:0]  maskM;
  int          t0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  audio_bsdac_regs u_audio_bsdac_regs (
    .clk(clk), .rstN(rstN), .sampleClk(clk), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut),
    .leftOut(leftOut), .rightOut(rightOut));

  function automatic logic [15:0] expL(logic [31:0] w, logic sw);
    return sw ? w[15:0] : w[31:16];
  endfunction
  function automatic logic [15:0] expR(logic [31:0] w, logic sw);
    return sw ? w[31:16] : w[15:0];
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdChk(logic [4:0] a, logic [31:0] exp, string tag);
    busAddr = a;
    #1;
    chk(busRdData == exp, tag, busRdData, exp);
  endtask

  task automatic outChk(string tag);
    chk(leftOut == expL(outM, swapM) && rightOut == expR(outM, swapM), tag,
        {leftOut, rightOut}, {expL(outM, swapM), expR(outM, swapM)});
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic waitCyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    v = $urandom(32'h5EED1);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    outM = '0; swapM = 1'b0; maskM = '0;
    // R1 reset state
    rdChk(A_DATA, 32'h0, "R1 data");
    rdChk(A_CTRL, 32'h0, "R1 ctrl");
    rdChk(A_MASK, 32'h0, "R1 mask");
    rdChk(A_STAT, 32'h0, "R1 status");
    chk(irqOut == 1'b0, "R1 irq", 32'(irqOut), 32'h0);
    outChk("R1 outputs");

    // random phase, converter disabled
    for (int i = 0; i < 60; i++) begin
      v = $urandom;
      case ($urandom_range(0, 3))
        0: begin
          wr(A_DATA, v); outM = v;
          rdChk(A_DATA, v, "R2 data readback");
          outChk("R8 R9 direct load");
        end
        1: begin
          v[31] = 1'b0;
          wr(A_CTRL, v); swapM = v[30];
          rdChk(A_CTRL, v & 32'h4000_0000, "R2 ctrl readback");
          outChk("R9 swap");
        end
        2: begin
          wr(A_MSET, v); maskM = maskM | v[29:28];
          rdChk(A_MASK, {2'b0, maskM, 28'h0}, "R3 mask set");
        end
        default: begin
          wr(A_MCLR, v); maskM = maskM & ~v[29:28];
          rdChk(A_MASK, {2'b0, maskM, 28'h0}, "R3 mask clear");
        end
      endcase
      chk(irqOut == 1'b0, "R10 irq idle", 32'(irqOut), 32'h0);
    end
    repeat (600) @(negedge clk);
    rdChk(A_STAT, 32'h0, "R8 ticks ignored status");
    outChk("R8 ticks ignored outputs");

    // directed: enable and find the first tick
    wr(A_CTRL, 32'h0); swapM = 1'b0;
    wr(A_DATA, 32'h1234_ABCD); outM = 32'h1234_ABCD;
    wr(A_MCLR, 32'hFFFF_FFFF); maskM = '0;
    wr(A_SCLR, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h8000_0000);
    busAddr = A_STAT;
    t0 = -1;
    for (int k = 0; k < 700 && t0 < 0; k++) begin
      @(negedge clk); #1;
      if (busRdData[28]) t0 = cyc;
    end
    chk(t0 >= 0, "R6 underrun seen", 32'(t0), 32'h0);
    rdChk(A_STAT, 32'h1000_0000, "R6 underrun only");
    outChk("R6 repeat frame");

    waitCyc(t0 + 9);
    wr(A_DATA, 32'hBEEF_0101);
    rdChk(A_STAT, 32'h1000_0000, "R7 ready clear after write");
    waitCyc(t0 + 255);
    outChk("R5 not before 256");
    waitCyc(t0 + 256);
    outM = 32'hBEEF_0101;
    outChk("R5 moved at tick");
    rdChk(A_STAT, 32'h3000_0000, "R5 ready set");

    wr(A_MSET, 32'h2000_0000);
    chk(irqOut == 1'b1, "R10 irq on ready", 32'(irqOut), 32'h1);
    wr(A_SCLR, 32'hDFFF_FFFF);
    rdChk(A_STAT, 32'h2000_0000, "R4 clear only underrun");
    wr(A_MCLR, 32'h2000_0000);
    chk(irqOut == 1'b0, "R10 irq masked", 32'(irqOut), 32'h0);
    wr(A_MSET, 32'h1000_0000);
    chk(irqOut == 1'b0, "R10 irq no source", 32'(irqOut), 32'h0);

    // collision with empty holding register
    waitCyc(t0 + 511);
    wr(A_DATA, 32'h0C0C_7777);
    outChk("R7 collide empty repeat");
    rdChk(A_STAT, 32'h1000_0000, "R7 collide empty status");
    rdChk(A_DATA, 32'h0C0C_7777, "R7 collide empty held");
    chk(irqOut == 1'b1, "R10 irq underrun", 32'(irqOut), 32'h1);
    waitCyc(t0 + 768);
    outM = 32'h0C0C_7777;
    outChk("R5 second move");
    rdChk(A_STAT, 32'h3000_0000, "R5 second ready");

    // collision with full holding register
    wr(A_SCLR, 32'h3000_0000);
    waitCyc(t0 + 899);
    wr(A_DATA, 32'h1111_2222);
    waitCyc(t0 + 1023);
    wr(A_DATA, 32'h3333_4444);
    outM = 32'h1111_2222;
    outChk("R7 collide full moved");
    rdChk(A_STAT, 32'h0, "R7 collide full status");
    rdChk(A_DATA, 32'h3333_4444, "R7 collide full held");
    waitCyc(t0 + 1280);
    outM = 32'h3333_4444;
    outChk("R5 after collide");
    rdChk(A_STAT, 32'h2000_0000, "R5 ready after collide");

    wr(A_CTRL, 32'hC000_0000); swapM = 1'b1;
    rdChk(A_CTRL, 32'hC000_0000, "R2 ctrl enabled");
    outChk("R9 swapped live");

    // disable and silence
    wr(A_CTRL, 32'h0); swapM = 1'b0;
    wr(A_DATA, 32'h0); outM = 32'h0;
    outChk("R8 silence");
    rdChk(A_STAT, 32'h0, "R7 write clears ready");
    repeat (600) @(negedge clk);
    outChk("R8 silence held");
    rdChk(A_STAT, 32'h0, "R8 status held");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule